// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control and address/count engine of one DMA channel. Software programs a source address, a destination address, a block count, a transfer count and a control word through a simple write port. Setting the run bit in the control word starts a run. The engine then performs block × transfer beats. Each beat reads one word from the source address and writes it to the destination address over a request/acknowledge memory port, which returns an error flag with each acknowledge.

After every good beat the source address steps by the word size. The destination address steps by the same amount unless it is pinned by a control bit. The transfer count runs down, and the block count drops each time the transfer count is used up. When the run ends, separate control bits decide whether the counts, the source address and the destination address return to their programmed start values or keep where the engine left them.

The end of every run posts a 3-bit cause code and a valid flag. One interrupt line is raised for a clean completion or for an error, and each of these has its own enable. The interrupt stays high until software clears the status.

Top module: `dma_seq_chan`

## Requirements
- R1: A write with `cfg_sel` 0, 1, 2 or 3 loads the source address, destination address, block count or transfer count respectively, and also its start copy, while the channel is idle. Such writes are ignored while `busy` is high. Select 4 writes the control word and select 5 clears the status.
- R2: The run bit is control bit 31, and a control write with it set while idle starts a run. Each beat is one read of the source address followed by one write of the read word to the destination address. The transfer count decrements per beat. When it would reach zero, the block count decrements and the transfer count is restored. A run of B blocks and T transfers makes B×T beats. A run started with B or T equal to 0 completes at once with no beat.
- R3: After each good beat the source address increases by STEP (4). The destination address also increases by STEP when control bit 24 is 0, and stays fixed when bit 24 is 1.
- R4: With control bit 23 set, both counts return to their start values when a run ends. With it clear, they keep their final values (0 and 0 after a completion).
- R5: With control bit 22 set, the source address returns to its start value at the end of a run, otherwise it keeps the next address. Control bit 21 does the same for the destination address.
- R6: The end of a run sets `stat_valid` and `stat_code`. The codes are 0 for completion, 1 for overflow, 2 for stop, 3 for source error and 4 for destination error. A write with select 5, or the start of a new run, clears `stat_valid`.
- R7: A beat whose source increment (or, when not fixed, destination increment) would carry past 2^AW−1 is not issued. The run ends with code 1 and the addresses unchanged.
- R8: Between beats, a high `stop_req` or a run bit cleared by a control write during the run ends the run with code 2.
- R9: An acknowledge with `mem_err` on the read ends the run with code 3, and on the write with code 4. The addresses and counts do not advance for that beat.
- R10: `irq` rises when status is posted if the code is 0 and control bit 19 is set, or if the code is nonzero and control bit 20 is set. It stays high until the status is cleared.
- R11: `mem_req` stays high until `mem_ack`, and is high only while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| stop_req | input | 1 | External stop request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ack | input | 1 | Access acknowledge |
| mem_err | input | 1 | Access error, valid with ack |
| busy | output | 1 | Run in progress |
| src_addr | output | AW | Working source address |
| dst_addr | output | AW | Working destination address |
| blk_cnt | output | CW | Working block count |
| xfr_cnt | output | CW | Working transfer count |
| stat_valid | output | 1 | Status posted |
| stat_code | output | 3 | Cause of the last run end |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the interaction of the reload bits with a fixed destination: a design that restores the wrong register would end a run with the source and destination addresses swapped or stepped. An address one step below the top of the space checks that the overflow test runs before the beat, so no wrapped access is issued. Errors injected on a read and then on a write check that the failing beat does not advance the counts or the addresses. Stop and disable requests placed mid-run, together with zero counts, check that the interrupt is masked by the correct enable for each cause.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_READ, ST_WRITE} seq_state_t;

  localparam logic [2:0] CODE_DONE   = 3'd0;
  localparam logic [2:0] CODE_OVF    = 3'd1;
  localparam logic [2:0] CODE_STOP   = 3'd2;
  localparam logic [2:0] CODE_SRCERR = 3'd3;
  localparam logic [2:0] CODE_DSTERR = 3'd4;

  localparam int CB_RUN    = 31;
  localparam int CB_FIXDST = 24;
  localparam int CB_RLDCNT = 23;
  localparam int CB_RLDSRC = 22;
  localparam int CB_RLDDST = 21;
  localparam int CB_ERRIE  = 20;
  localparam int CB_DONEIE = 19;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_BLK  = 3'd2;
  localparam logic [2:0] SEL_XFR  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_CLR  = 3'd5;
endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int AW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  input  logic          hold,
  input  logic          restore,
  output logic [AW-1:0] addr,
  output logic          wrap
);
  localparam logic [AW:0] STEP_W = (AW+1)'(STEP);

  logic [AW-1:0] cur_q;
  logic [AW-1:0] start_q;
  logic [AW:0]   sum;

  assign sum  = {1'b0, cur_q} + STEP_W;
  assign wrap = sum[AW] & ~hold;
  assign addr = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      start_q <= '0;
    end else if (load) begin
      cur_q   <= load_val;
      start_q <= load_val;
    end else if (restore) begin
      cur_q <= start_q;
    end else if (advance && !hold) begin
      cur_q <= sum[AW-1:0];
    end
  end
endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_blk,
  input  logic          load_xfr,
  input  logic [CW-1:0] load_val,
  input  logic          beat,
  input  logic          restore,
  output logic [CW-1:0] blk,
  output logic [CW-1:0] xfr,
  output logic          empty,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] blk_q, xfr_q, blk_start_q, xfr_start_q;

  assign blk   = blk_q;
  assign xfr   = xfr_q;
  assign empty = (blk_q == '0) || (xfr_q == '0);
  assign last  = (blk_q == ONE) && (xfr_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q       <= '0;
      xfr_q       <= '0;
      blk_start_q <= '0;
      xfr_start_q <= '0;
    end else begin
      if (load_blk) begin
        blk_q       <= load_val;
        blk_start_q <= load_val;
      end
      if (load_xfr) begin
        xfr_q       <= load_val;
        xfr_start_q <= load_val;
      end
      if (restore) begin
        blk_q <= blk_start_q;
        xfr_q <= xfr_start_q;
      end else if (beat) begin
        if (xfr_q == ONE) begin
          if (blk_q == ONE) begin
            blk_q <= '0;
            xfr_q <= '0;
          end else begin
            blk_q <= blk_q - ONE;
            xfr_q <= xfr_start_q;
          end
        end else begin
          xfr_q <= xfr_q - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int CW   = 8,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          stop_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          busy,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] blk_cnt,
  output logic [CW-1:0] xfr_cnt,
  output logic          stat_valid,
  output logic [2:0]    stat_code,
  output logic          irq
);
  seq_state_t    st_q;
  logic          run_q, fd_q, rc_q, rs_q, rd_q, ei_q, ci_q;
  logic          sv_q, irq_q, req_q, we_q;
  logic [2:0]    code_q;
  logic [AW-1:0] maddr_q;
  logic [DW-1:0] wdata_q;

  logic idle, finish, issue, step;
  logic [2:0] fin_code;
  logic src_wrap, dst_wrap, cnt_empty, cnt_last;
  logic ld_src, ld_dst, ld_blk, ld_xfr;
  logic unused_cfg;

  assign unused_cfg = ^cfg_wdata;
  assign idle   = (st_q == ST_IDLE);
  assign ld_src = cfg_we && idle && (cfg_sel == SEL_SRC);
  assign ld_dst = cfg_we && idle && (cfg_sel == SEL_DST);
  assign ld_blk = cfg_we && idle && (cfg_sel == SEL_BLK);
  assign ld_xfr = cfg_we && idle && (cfg_sel == SEL_XFR);
  assign step   = (st_q == ST_WRITE) && mem_ack && !mem_err;

  always_comb begin
    finish   = 1'b0;
    fin_code = CODE_DONE;
    issue    = 1'b0;
    unique case (st_q)
      ST_ISSUE: begin
        if (stop_req || !run_q) begin
          finish = 1'b1; fin_code = CODE_STOP;
        end else if (cnt_empty) begin
          finish = 1'b1; fin_code = CODE_DONE;
        end else if (src_wrap || dst_wrap) begin
          finish = 1'b1; fin_code = CODE_OVF;
        end else begin
          issue = 1'b1;
        end
      end
      ST_READ: begin
        if (mem_ack && mem_err) begin
          finish = 1'b1; fin_code = CODE_SRCERR;
        end
      end
      ST_WRITE: begin
        if (mem_ack && mem_err) begin
          finish = 1'b1; fin_code = CODE_DSTERR;
        end else if (mem_ack && cnt_last) begin
          finish = 1'b1; fin_code = CODE_DONE;
        end
      end
      default: ;
    endcase
  end

  dma_seq_addr #(.AW(AW), .STEP(STEP)) u_src (
    .clk(clk), .rst(rst), .load(ld_src), .load_val(cfg_wdata[AW-1:0]),
    .advance(step), .hold(1'b0), .restore(finish && rs_q),
    .addr(src_addr), .wrap(src_wrap)
  );

  dma_seq_addr #(.AW(AW), .STEP(STEP)) u_dst (
    .clk(clk), .rst(rst), .load(ld_dst), .load_val(cfg_wdata[AW-1:0]),
    .advance(step), .hold(fd_q), .restore(finish && rd_q),
    .addr(dst_addr), .wrap(dst_wrap)
  );

  dma_seq_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load_blk(ld_blk), .load_xfr(ld_xfr),
    .load_val(cfg_wdata[CW-1:0]), .beat(step), .restore(finish && rc_q),
    .blk(blk_cnt), .xfr(xfr_cnt), .empty(cnt_empty), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      run_q   <= 1'b0;
      fd_q    <= 1'b0;
      rc_q    <= 1'b0;
      rs_q    <= 1'b0;
      rd_q    <= 1'b0;
      ei_q    <= 1'b0;
      ci_q    <= 1'b0;
      sv_q    <= 1'b0;
      irq_q   <= 1'b0;
      code_q  <= CODE_DONE;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      maddr_q <= '0;
      wdata_q <= '0;
    end else begin
      if (cfg_we && cfg_sel == SEL_CLR) begin
        sv_q  <= 1'b0;
        irq_q <= 1'b0;
      end
      if (cfg_we && cfg_sel == SEL_CTRL) begin
        run_q <= cfg_wdata[CB_RUN];
        if (idle) begin
          fd_q <= cfg_wdata[CB_FIXDST];
          rc_q <= cfg_wdata[CB_RLDCNT];
          rs_q <= cfg_wdata[CB_RLDSRC];
          rd_q <= cfg_wdata[CB_RLDDST];
          ei_q <= cfg_wdata[CB_ERRIE];
          ci_q <= cfg_wdata[CB_DONEIE];
          if (cfg_wdata[CB_RUN]) begin
            st_q  <= ST_ISSUE;
            sv_q  <= 1'b0;
            irq_q <= 1'b0;
          end
        end
      end
      if (issue) begin
        req_q   <= 1'b1;
        we_q    <= 1'b0;
        maddr_q <= src_addr;
        st_q    <= ST_READ;
      end
      if (st_q == ST_READ && mem_ack && !mem_err) begin
        wdata_q <= mem_rdata;
        we_q    <= 1'b1;
        maddr_q <= dst_addr;
        st_q    <= ST_WRITE;
      end
      if (step && !cnt_last) begin
        req_q <= 1'b0;
        we_q  <= 1'b0;
        st_q  <= ST_ISSUE;
      end
      if (finish) begin
        st_q   <= ST_IDLE;
        req_q  <= 1'b0;
        we_q   <= 1'b0;
        run_q  <= 1'b0;
        sv_q   <= 1'b1;
        code_q <= fin_code;
        irq_q  <= (fin_code == CODE_DONE) ? ci_q : ei_q;
      end
    end
  end

  assign busy       = !idle;
  assign mem_req    = req_q;
  assign mem_we     = we_q;
  assign mem_addr   = maddr_q;
  assign mem_wdata  = wdata_q;
  assign stat_valid = sv_q;
  assign stat_code  = code_q;
  assign irq        = irq_q;
endmodule

// File: rtl/dma_seq_chan_chk.sv
module dma_seq_chan_chk #(
  parameter int AW   = 16,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          stat_valid,
  input logic [2:0]    stat_code,
  input logic          irq,
  input logic          fd_q,
  input logic          ci_q,
  input logic          ei_q
);
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq |-> stat_valid);

  a_r10_irq_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ((stat_code == 3'd0) ? $past(ci_q) : $past(ei_q)));

  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);

  a_r11_req_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  a_r3_fixed_dst: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && fd_q) |-> $stable(dst_addr));

  a_r3_src_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (src_addr != $past(src_addr)))
      |-> (src_addr == $past(src_addr) + STEP_A));

  a_r6_end_posts: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> stat_valid);
endmodule

bind dma_seq_chan dma_seq_chan_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
  .src_addr(src_addr), .dst_addr(dst_addr), .stat_valid(stat_valid),
  .stat_code(stat_code), .irq(irq), .fd_q(fd_q), .ci_q(ci_q), .ei_q(ei_q)
);

// File: tb/dma_seq_chan_bench.sv
module dma_seq_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 32, CW = 8, STEP = 4;
  localparam int AMAX = (1 << AW) - 1;
  localparam int RUN = 1 << 31, FIX = 1 << 24, RCNT = 1 << 23,
                 RSRC = 1 << 22, RDST = 1 << 21, EIE = 1 << 20, CIE = 1 << 19;

  logic clk = 0, rst = 1;
  logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic stop_req = 0;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [AW-1:0] mem_addr; logic [DW-1:0] mem_wdata, mem_rdata;
  logic busy, stat_valid, irq; logic [2:0] stat_code;
  logic [AW-1:0] src_addr, dst_addr; logic [CW-1:0] blk_cnt, xfr_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_seq_chan #(.AW(AW), .DW(DW), .CW(CW), .STEP(STEP)) u_dma_seq_chan (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .stop_req(stop_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .busy(busy), .src_addr(src_addr), .dst_addr(dst_addr), .blk_cnt(blk_cnt),
    .xfr_cnt(xfr_cnt), .stat_valid(stat_valid), .stat_code(stat_code), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0, beats = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model
  int lat = 0, wcnt = 0;
  bit err_on = 0, err_we = 0; int err_addr = 0;
  assign mem_rdata = 32'h5A000000 | 32'(mem_addr);
  always @(negedge clk) begin
    if (mem_req && wcnt >= lat) begin
      mem_ack = 1; wcnt = 0;
      mem_err = err_on && (int'(mem_addr) == err_addr) && (mem_we == err_we);
    end else begin
      mem_ack = 0; mem_err = 0;
      wcnt = mem_req ? wcnt + 1 : 0;
    end
  end

  always @(posedge clk) if (mem_req && mem_we && mem_ack && !mem_err) beats++;

  // behavioural reference model
  int m_st, m_src, m_dst, m_ssrc, m_sdst, m_blk, m_xfr, m_sblk, m_sxfr;
  int m_fd, m_rc, m_rs, m_rd, m_ei, m_ci, m_en, m_sv, m_code, m_irq;
  int m_req, m_we, m_addr; logic [31:0] m_wd;

  task automatic model_reset();
    m_st = 0; m_src = 0; m_dst = 0; m_ssrc = 0; m_sdst = 0; m_blk = 0; m_xfr = 0;
    m_sblk = 0; m_sxfr = 0; m_fd = 0; m_rc = 0; m_rs = 0; m_rd = 0; m_ei = 0;
    m_ci = 0; m_en = 0; m_sv = 0; m_code = 0; m_irq = 0; m_req = 0; m_we = 0;
    m_addr = 0; m_wd = 0;
  endtask

  task automatic model_end(int code);
    if (m_rc != 0) begin m_blk = m_sblk; m_xfr = m_sxfr; end
    if (m_rs != 0) m_src = m_ssrc;
    if (m_rd != 0) m_dst = m_sdst;
    m_sv = 1; m_code = code; m_irq = (code == 0) ? m_ci : m_ei;
    m_st = 0; m_req = 0; m_we = 0; m_en = 0;
  endtask

  task automatic model_step();
    int ost, oen, d;
    ost = m_st; oen = m_en; d = int'(cfg_wdata);
    if (cfg_we && cfg_sel == 5) begin m_sv = 0; m_irq = 0; end
    if (cfg_we && cfg_sel == 4) begin
      m_en = cfg_wdata[31];
      if (ost == 0) begin
        m_fd = cfg_wdata[24]; m_rc = cfg_wdata[23]; m_rs = cfg_wdata[22];
        m_rd = cfg_wdata[21]; m_ei = cfg_wdata[20]; m_ci = cfg_wdata[19];
        if (cfg_wdata[31]) begin m_st = 1; m_sv = 0; m_irq = 0; end
      end
    end
    if (cfg_we && ost == 0) begin
      if (cfg_sel == 0) begin m_src = d & AMAX; m_ssrc = m_src; end
      if (cfg_sel == 1) begin m_dst = d & AMAX; m_sdst = m_dst; end
      if (cfg_sel == 2) begin m_blk = d & 255; m_sblk = m_blk; end
      if (cfg_sel == 3) begin m_xfr = d & 255; m_sxfr = m_xfr; end
    end
    case (ost)
      1: if (stop_req || oen == 0) model_end(2);
         else if (m_blk == 0 || m_xfr == 0) model_end(0);
         else if (m_src + STEP > AMAX || (m_fd == 0 && m_dst + STEP > AMAX)) model_end(1);
         else begin m_req = 1; m_we = 0; m_addr = m_src; m_st = 2; end
      2: if (mem_ack) begin
           if (mem_err) model_end(3);
           else begin m_wd = mem_rdata; m_we = 1; m_addr = m_dst; m_st = 3; end
         end
      3: if (mem_ack) begin
           if (mem_err) model_end(4);
           else begin
             bit lastb;
             lastb = (m_blk == 1 && m_xfr == 1);
             m_src += STEP;
             if (m_fd == 0) m_dst += STEP;
             if (m_xfr == 1) begin
               if (m_blk == 1) begin m_blk = 0; m_xfr = 0; end
               else begin m_blk -= 1; m_xfr = m_sxfr; end
             end else m_xfr -= 1;
             if (lastb) model_end(0);
             else begin m_req = 0; m_we = 0; m_st = 1; end
           end
         end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) model_reset(); else model_step();
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 busy", int'(busy), int'(m_st != 0));
      chk("R3 src_addr", int'(src_addr), m_src);
      chk("R3 dst_addr", int'(dst_addr), m_dst);
      chk("R2 blk_cnt", int'(blk_cnt), m_blk);
      chk("R2 xfr_cnt", int'(xfr_cnt), m_xfr);
      chk("R6 stat_valid", int'(stat_valid), m_sv);
      chk("R6 stat_code", int'(stat_code), m_code);
      chk("R10 irq", int'(irq), m_irq);
      chk("R11 mem_req", int'(mem_req), m_req);
      if (m_req != 0) begin
        chk("R2 mem_we", int'(mem_we), m_we);
        chk("R2 mem_addr", int'(mem_addr), m_addr);
        if (m_we != 0) chk("R2 mem_wdata", int'(mem_wdata), int'(m_wd));
      end
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = 32'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(int s, int d, int b, int t);
    wr(5, 0); wr(0, s); wr(1, d); wr(2, b); wr(3, t);
    beats = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic fin();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      fin();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R6 reset stat_valid", int'(stat_valid), 0);
    chk("R10 reset irq", int'(irq), 0);
    chk("R2 reset busy", int'(busy), 0);

    // A: 2x3 run, incrementing addresses, no reload; R1 write while busy ignored
    setup('h0100, 'h0200, 2, 3);
    wr(4, RUN | CIE);
    wr(0, 'h7777);
    wait_idle();
    chk("R2 beats 2x3", beats, 6);
    chk("R1 busy write ignored, R3 src", int'(src_addr), 'h0118);
    chk("R5 dst kept next", int'(dst_addr), 'h0218);
    chk("R4 counts not reloaded", int'(blk_cnt) + int'(xfr_cnt), 0);
    chk("R6 code done", int'(stat_code), 0);
    chk("R10 done irq", int'(irq), 1);
    wr(5, 0);
    chk("R6 clear valid", int'(stat_valid), 0);
    chk("R10 clear irq", int'(irq), 0);

    // B: fixed destination, all reloads, wait state, done irq masked
    lat = 1;
    setup('h0400, 'h0800, 3, 2);
    wr(4, RUN | FIX | RCNT | RSRC | RDST | EIE);
    wait_idle();
    chk("R2 beats 3x2", beats, 6);
    chk("R4 blk reloaded", int'(blk_cnt), 3);
    chk("R4 xfr reloaded", int'(xfr_cnt), 2);
    chk("R5 src reloaded", int'(src_addr), 'h0400);
    chk("R5 dst reloaded", int'(dst_addr), 'h0800);
    chk("R10 done irq masked", int'(irq), 0);
    lat = 0;

    // C: overflow at top of address space
    setup('hFFF8, 'h1000, 1, 4);
    wr(4, RUN | EIE);
    wait_idle();
    chk("R7 beats before overflow", beats, 1);
    chk("R7 code overflow", int'(stat_code), 1);
    chk("R7 src not wrapped", int'(src_addr), 'hFFFC);
    chk("R10 error irq", int'(irq), 1);

    // D: external stop, error irq disabled
    setup('h2000, 'h3000, 1, 20);
    wr(4, RUN);
    repeat (7) @(negedge clk);
    stop_req = 1;
    wait_idle();
    stop_req = 0;
    chk("R8 code stop", int'(stat_code), 2);
    chk("R8 partial run", int'(beats > 0 && beats < 20), 1);
    chk("R10 stop irq masked", int'(irq), 0);

    // E: software disable mid-run
    setup('h2000, 'h3000, 1, 20);
    wr(4, RUN | EIE);
    repeat (5) @(negedge clk);
    wr(4, EIE);
    wait_idle();
    chk("R8 disable code", int'(stat_code), 2);
    chk("R10 disable irq", int'(irq), 1);

    // F: source access error
    err_on = 1; err_we = 0; err_addr = 'h4008;
    setup('h4000, 'h5000, 1, 5);
    wr(4, RUN | EIE);
    wait_idle();
    chk("R9 src err beats", beats, 2);
    chk("R9 src err code", int'(stat_code), 3);
    chk("R9 src not advanced", int'(src_addr), 'h4008);
    chk("R9 xfr not advanced", int'(xfr_cnt), 3);

    // G: destination access error
    err_we = 1; err_addr = 'h5004;
    setup('h4000, 'h5000, 1, 5);
    wr(4, RUN | EIE);
    wait_idle();
    err_on = 0;
    chk("R9 dst err beats", beats, 1);
    chk("R9 dst err code", int'(stat_code), 4);
    chk("R9 dst not advanced", int'(dst_addr), 'h5004);

    // H: zero block count completes at once
    setup('h6000, 'h7000, 0, 5);
    wr(4, RUN | CIE);
    wait_idle();
    chk("R2 zero count beats", beats, 0);
    chk("R2 zero count code", int'(stat_code), 0);
    chk("R10 zero count irq", int'(irq), 1);
    chk("R1 src loaded", int'(src_addr), 'h6000);

    repeat (3) @(negedge clk);
    fin();
  end
endmodule